// File: doc/BRIEF.md
# Integer Pipe Steering and Writeback Ordering

This block issues decoded integer micro-ops into a cluster of four execution pipes that do not share the same capabilities or depths. A branch pipe handles direct branches. Three arithmetic pipes, X, Y and Z, all handle simple ALU work. Multiplies can run only on X, which is the deepest pipe. Indirect branches can run only on Z. Each cycle the block looks at the class of the presented micro-op, finds a capable pipe that is not held, and puts the micro-op into the first stage of that pipe. The pipes are fixed-length shift registers, so a result reaches the end of its pipe a known number of cycles after issue.

All pipes share one writeback port. When several pipes have a finished result in the same cycle, the result issued earliest is written back. Every other pipe with a finished result freezes in place and tries again in the next cycle. A frozen pipe accepts no new work. If the presented micro-op has no free capable pipe, the block drops its ready signal and the sender must keep the micro-op on its inputs. Each micro-op carries a tag from the sender. The tag comes back on the writeback port together with the pipe number and a simple result, so completion order can be checked against issue order.

Top module: `int_steer_cluster`

## Requirements
- R1: After reset, no writeback is presented (wb_valid low) and in_ready is high for every class.
- R2: Class encoding on in_class: 0 simple ALU, 1 multiply, 2 direct branch, 3 indirect branch. A multiply issues only to pipe X, a direct branch only to the branch pipe, and an indirect branch only to pipe Z. Pipe numbers on wb_pipe are: 0 branch pipe, 1 X, 2 Y, 3 Z.
- R3: A simple ALU op issues to the first pipe that is not held, checked in the order Y, then Z, then X. It never issues to the branch pipe.
- R4: If a micro-op is not delayed, it is presented on the writeback port during the L-th clock cycle after the edge that accepted it. L is 1 for the branch pipe, 4 for X, and 2 for Y and for Z.
- R5: The block presents at most one result per cycle. When several pipes hold a finished result, the one accepted earliest is presented.
- R6: A pipe whose finished result is not presented is held. None of its stages advance and it accepts no micro-op that cycle. Its result is offered again in the next cycle.
- R7: in_ready is low exactly when no pipe capable of the presented class is free. A micro-op presented while in_ready is low is not accepted and has no effect.
- R8: The tag given with a micro-op is returned unchanged on wb_tag when its result is presented.
- R9: wb_data is the low DATA_W bits of the result. The result is opa+opb for a simple ALU op, opa*opb for a multiply, opa+opb for a direct branch, and opa for an indirect branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A micro-op is presented |
| in_class | input | 2 | Micro-op class (R2 encoding) |
| in_tag | input | TAG_W | Sender tag carried to writeback |
| in_opa | input | DATA_W | First operand |
| in_opb | input | DATA_W | Second operand |
| in_ready | output | 1 | A capable pipe is free; the micro-op is accepted on this edge if in_valid |
| wb_valid | output | 1 | A result is presented this cycle |
| wb_pipe | output | 2 | Pipe that produced the result |
| wb_tag | output | TAG_W | Tag of the presented result |
| wb_data | output | DATA_W | Result value |

## Verification
The hardest state to reach is a cascade of freezes. An older result on X forces Y and Z to be held in the same stretch of cycles. A later ALU op then falls through to X, or an indirect branch stalls behind a frozen Z. This only happens when the issue slots are spaced so that the pipe ends line up despite their different depths. A scripted opening places multiplies two and three cycles ahead of ALU ops and indirect branches so that their ends meet. A long weighted random stream with few idle cycles then keeps all four pipes busy. A behavioural age-ordered model compares ready, pipe, tag and data every cycle.

// File: rtl/int_steer_pkg.sv
package int_steer_pkg;

   typedef enum logic [1:0] {
      UOP_ALU = 2'd0,
      UOP_MUL = 2'd1,
      UOP_DBR = 2'd2,
      UOP_IBR = 2'd3
   } uop_class_e;

   localparam int NPIPE  = 4;
   localparam int PIPE_B = 0;
   localparam int PIPE_X = 1;
   localparam int PIPE_Y = 2;
   localparam int PIPE_Z = 3;

   // Pipes able to execute a given class, one bit per pipe index.
   function automatic logic [NPIPE-1:0] cap_mask(uop_class_e c);
      logic [NPIPE-1:0] m;
      m = '0;
      case (c)
         UOP_ALU: begin
            m[PIPE_X] = 1'b1;
            m[PIPE_Y] = 1'b1;
            m[PIPE_Z] = 1'b1;
         end
         UOP_MUL: m[PIPE_X] = 1'b1;
         UOP_DBR: m[PIPE_B] = 1'b1;
         UOP_IBR: m[PIPE_Z] = 1'b1;
         default: m = '0;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/steer_lane.sv
// Fixed-depth execution lane: a shift register that freezes as a whole when held.
module steer_lane #(
   parameter int DEPTH  = 2,
   parameter int SEQ_W  = 5,
   parameter int TAG_W  = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              ins_valid,
   input  logic [SEQ_W-1:0]  ins_seq,
   input  logic [TAG_W-1:0]  ins_tag,
   input  logic [DATA_W-1:0] ins_data,
   output logic              head_valid,
   output logic [SEQ_W-1:0]  head_seq,
   output logic [TAG_W-1:0]  head_tag,
   output logic [DATA_W-1:0] head_data
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("steer_lane: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic              vld_q;
      logic [SEQ_W-1:0]  seq_q;
      logic [TAG_W-1:0]  tag_q;
      logic [DATA_W-1:0] dat_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            seq_q <= '0;
            tag_q <= '0;
            dat_q <= '0;
         end else if (!hold) begin
            vld_q <= ins_valid;
            seq_q <= ins_seq;
            tag_q <= ins_tag;
            dat_q <= ins_data;
         end
      end

      assign head_valid = vld_q;
      assign head_seq   = seq_q;
      assign head_tag   = tag_q;
      assign head_data  = dat_q;
   end else begin : g_chain
      logic [DEPTH-1:0]  vld_q;
      logic [SEQ_W-1:0]  seq_q [DEPTH];
      logic [TAG_W-1:0]  tag_q [DEPTH];
      logic [DATA_W-1:0] dat_q [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
               seq_q[i] <= '0;
               tag_q[i] <= '0;
               dat_q[i] <= '0;
            end
         end else if (!hold) begin
            vld_q    <= {vld_q[DEPTH-2:0], ins_valid};
            seq_q[0] <= ins_seq;
            tag_q[0] <= ins_tag;
            dat_q[0] <= ins_data;
            for (int i = 1; i < DEPTH; i++) begin
               seq_q[i] <= seq_q[i-1];
               tag_q[i] <= tag_q[i-1];
               dat_q[i] <= dat_q[i-1];
            end
         end
      end

      assign head_valid = vld_q[DEPTH-1];
      assign head_seq   = seq_q[DEPTH-1];
      assign head_tag   = tag_q[DEPTH-1];
      assign head_data  = dat_q[DEPTH-1];
   end

endmodule

// File: rtl/steer_select.sv
// Chooses the destination pipe for the presented micro-op.
module steer_select
   import int_steer_pkg::*;
#(
   parameter int unsigned ALU_PRIO0 = PIPE_Y,
   parameter int unsigned ALU_PRIO1 = PIPE_Z,
   parameter int unsigned ALU_PRIO2 = PIPE_X
) (
   input  logic             in_valid,
   input  logic [1:0]       in_class,
   input  logic [NPIPE-1:0] pipe_free,
   output logic [NPIPE-1:0] issue_sel,
   output logic             ready
);

   localparam int unsigned PRIO_N = 3;
   localparam int unsigned PRIO [PRIO_N] = '{ALU_PRIO0, ALU_PRIO1, ALU_PRIO2};
   localparam logic [NPIPE-1:0] ALU_CAP = cap_mask(UOP_ALU);

   for (genvar k = 0; k < PRIO_N; k++) begin : g_prio_chk
      if (PRIO[k] >= NPIPE || !ALU_CAP[PRIO[k]]) begin : g_bad
         $error("steer_select: ALU priority entry names a pipe without ALU capability");
      end
   end
   if (ALU_PRIO0 == ALU_PRIO1 || ALU_PRIO0 == ALU_PRIO2 || ALU_PRIO1 == ALU_PRIO2) begin : g_dup
      $error("steer_select: ALU priority entries must be distinct");
   end

   uop_class_e       cls;
   logic [NPIPE-1:0] avail;
   logic [NPIPE-1:0] pick;

   always_comb begin
      cls   = uop_class_e'(in_class);
      avail = cap_mask(cls) & pipe_free;
      pick  = '0;
      if (cls == UOP_ALU) begin
         for (int k = 0; k < PRIO_N; k++) begin
            if (avail[PRIO[k]] && (pick == '0)) begin
               pick[PRIO[k]] = 1'b1;
            end
         end
      end else begin
         pick = avail;
      end
      ready     = |avail;
      issue_sel = in_valid ? pick : '0;
   end

endmodule

// File: rtl/wb_oldest_arb.sv
// Grants the single writeback slot to the oldest finished result.
module wb_oldest_arb #(
   parameter int N     = 4,
   parameter int SEQ_W = 5
) (
   input  logic [N-1:0]     req,
   input  logic [SEQ_W-1:0] seq [N],
   output logic [N-1:0]     gnt
);

   // Wrap-aware age: a is older than b when a-b is negative.
   function automatic logic is_older(logic [SEQ_W-1:0] a, logic [SEQ_W-1:0] b);
      logic [SEQ_W-1:0] d;
      d = a - b;
      return d[SEQ_W-1];
   endfunction

   always_comb begin
      for (int i = 0; i < N; i++) begin
         gnt[i] = req[i];
         for (int j = 0; j < N; j++) begin
            if (j != i && req[j] && !is_older(seq[i], seq[j])) begin
               gnt[i] = 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/int_steer_cluster.sv
module int_steer_cluster
   import int_steer_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int TAG_W  = 6,
   parameter int SEQ_W  = 5,
   parameter int LAT_B  = 1,
   parameter int LAT_X  = 4,
   parameter int LAT_Y  = 2,
   parameter int LAT_Z  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        in_class,
   input  logic [TAG_W-1:0]  in_tag,
   input  logic [DATA_W-1:0] in_opa,
   input  logic [DATA_W-1:0] in_opb,
   output logic              in_ready,
   output logic              wb_valid,
   output logic [1:0]        wb_pipe,
   output logic [TAG_W-1:0]  wb_tag,
   output logic [DATA_W-1:0] wb_data
);

   localparam int INFLIGHT_MAX = LAT_B + LAT_X + LAT_Y + LAT_Z;

   function automatic int lane_depth(int p);
      case (p)
         PIPE_B:  return LAT_B;
         PIPE_X:  return LAT_X;
         PIPE_Y:  return LAT_Y;
         default: return LAT_Z;
      endcase
   endfunction

   if (LAT_B < 1 || LAT_X < 1 || LAT_Y < 1 || LAT_Z < 1) begin : g_bad_lat
      $error("int_steer_cluster: every pipe latency must be at least 1");
   end
   if ((1 << (SEQ_W - 1)) <= INFLIGHT_MAX) begin : g_bad_seq
      $error("int_steer_cluster: SEQ_W too narrow for the in-flight window");
   end
   if (DATA_W < 1 || TAG_W < 1) begin : g_bad_w
      $error("int_steer_cluster: widths must be positive");
   end

   logic [NPIPE-1:0]  issue_sel;
   logic [NPIPE-1:0]  pipe_free;
   logic [NPIPE-1:0]  head_valid;
   logic [NPIPE-1:0]  wb_gnt;
   logic [SEQ_W-1:0]  head_seq  [NPIPE];
   logic [TAG_W-1:0]  head_tag  [NPIPE];
   logic [DATA_W-1:0] head_data [NPIPE];
   logic [SEQ_W-1:0]  seq_q;
   logic [DATA_W-1:0] exec_res;
   logic              accept;

   // Steering
   steer_select u_select (
      .in_valid  (in_valid),
      .in_class  (in_class),
      .pipe_free (pipe_free),
      .issue_sel (issue_sel),
      .ready     (in_ready)
   );

   assign accept = in_valid & in_ready;

   // Issue age counter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q <= '0;
      end else if (accept) begin
         seq_q <= seq_q + 1'b1;
      end
   end

   // Result model, computed once at issue and carried down the lane
   always_comb begin
      case (uop_class_e'(in_class))
         UOP_ALU: exec_res = in_opa + in_opb;
         UOP_MUL: exec_res = in_opa * in_opb;
         UOP_DBR: exec_res = in_opa + in_opb;
         default: exec_res = in_opa;
      endcase
   end

   // Lanes
   for (genvar p = 0; p < NPIPE; p++) begin : g_lane
      steer_lane #(
         .DEPTH  (lane_depth(p)),
         .SEQ_W  (SEQ_W),
         .TAG_W  (TAG_W),
         .DATA_W (DATA_W)
      ) u_lane (
         .clk        (clk),
         .rst_n      (rst_n),
         .hold       (~pipe_free[p]),
         .ins_valid  (issue_sel[p]),
         .ins_seq    (seq_q),
         .ins_tag    (in_tag),
         .ins_data   (exec_res),
         .head_valid (head_valid[p]),
         .head_seq   (head_seq[p]),
         .head_tag   (head_tag[p]),
         .head_data  (head_data[p])
      );
      assign pipe_free[p] = ~(head_valid[p] & ~wb_gnt[p]);
   end

   // Writeback arbitration
   wb_oldest_arb #(
      .N     (NPIPE),
      .SEQ_W (SEQ_W)
   ) u_arb (
      .req (head_valid),
      .seq (head_seq),
      .gnt (wb_gnt)
   );

   always_comb begin
      wb_valid = 1'b0;
      wb_pipe  = '0;
      wb_tag   = '0;
      wb_data  = '0;
      for (int p = 0; p < NPIPE; p++) begin
         if (wb_gnt[p]) begin
            wb_valid = 1'b1;
            wb_pipe  = 2'(p);
            wb_tag   = head_tag[p];
            wb_data  = head_data[p];
         end
      end
   end

endmodule

// File: rtl/int_steer_chk.sv
module int_steer_chk
   import int_steer_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [1:0]       in_class,
   input logic             in_ready,
   input logic [NPIPE-1:0] issue_sel,
   input logic [NPIPE-1:0] pipe_free,
   input logic [NPIPE-1:0] head_valid,
   input logic [NPIPE-1:0] wb_gnt,
   input logic             wb_valid
);

   localparam logic [NPIPE-1:0] ONLY_B = 4'b0001;
   localparam logic [NPIPE-1:0] ONLY_X = 4'b0010;
   localparam logic [NPIPE-1:0] ONLY_Z = 4'b1000;

   // R2
   mul_to_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_class == 2'(UOP_MUL)) |-> issue_sel == ONLY_X);

   // R2
   dbr_to_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_class == 2'(UOP_DBR)) |-> issue_sel == ONLY_B);

   // R2
   ibr_to_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_class == 2'(UOP_IBR)) |-> issue_sel == ONLY_Z);

   // R3
   alu_prefers_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_class == 2'(UOP_ALU) && pipe_free[PIPE_Y]) |-> issue_sel[PIPE_Y]);

   // R3
   alu_not_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_class == 2'(UOP_ALU)) |-> !issue_sel[PIPE_B]);

   // R5
   single_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wb_gnt) && ((|head_valid) == wb_valid));

   // R7
   stall_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> issue_sel == '0);

   for (genvar p = 0; p < NPIPE; p++) begin : g_lane_chk
      // R6
      held_keeps_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (head_valid[p] && !wb_gnt[p]) |=> head_valid[p]);
      // R6
      held_no_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (head_valid[p] && !wb_gnt[p]) |-> !issue_sel[p]);
   end

endmodule

bind int_steer_cluster int_steer_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_class   (in_class),
   .in_ready   (in_ready),
   .issue_sel  (issue_sel),
   .pipe_free  (pipe_free),
   .head_valid (head_valid),
   .wb_gnt     (wb_gnt),
   .wb_valid   (wb_valid)
);

// File: tb/test_int_steer_cluster.sv
module test_int_steer_cluster;

   localparam int CLK_PERIOD = 10;
   localparam int DW         = 16;
   localparam int TW         = 6;
   localparam int SCRIPT_LEN = 24;
   localparam int RAND_OPS   = 3000;
   localparam int RUN_CYCLES = 4200;
   localparam int SLOTS      = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [1:0]    in_class = 2'd0;
   logic [TW-1:0] in_tag = '0;
   logic [DW-1:0] in_opa = '0;
   logic [DW-1:0] in_opb = '0;
   logic          in_ready;
   logic          wb_valid;
   logic [1:0]    wb_pipe;
   logic [TW-1:0] wb_tag;
   logic [DW-1:0] wb_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   int_steer_cluster i_int_steer_cluster (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_class (in_class),
      .in_tag   (in_tag),
      .in_opa   (in_opa),
      .in_opb   (in_opb),
      .in_ready (in_ready),
      .wb_valid (wb_valid),
      .wb_pipe  (wb_pipe),
      .wb_tag   (wb_tag),
      .wb_data  (wb_data)
   );

   // Reference state: one record per in-flight micro-op
   int        lat [4] = '{1, 4, 2, 2};
   bit        mv   [SLOTS];
   int        mp   [SLOTS];
   int        mpos [SLOTS];
   int        mseq [SLOTS];
   int        mtag [SLOTS];
   int        mdat [SLOTS];
   int        next_seq = 0;
   int        n_vec = 0;
   int        n_bad = 0;
   bit        done = 1'b0;
   bit        acc;

   function automatic int ref_result(int c, logic [DW-1:0] a, logic [DW-1:0] b);
      logic [DW-1:0] r;
      case (c)
         0: r = a + b;
         1: r = a * b;
         2: r = a + b;
         default: r = a;
      endcase
      return int'(r);
   endfunction

   task automatic check(string req, string what, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // One cycle of the reference: compare, then advance as the coming edge will
   task automatic model_cycle();
      int  win;
      int  ch;
      bit  frz [4];
      win = -1;
      for (int p = 0; p < 4; p++) frz[p] = 1'b0;
      for (int i = 0; i < SLOTS; i++) begin
         if (mv[i] && mpos[i] == lat[mp[i]] - 1) begin
            if (win < 0 || mseq[i] < mseq[win]) win = i;
         end
      end
      for (int i = 0; i < SLOTS; i++) begin
         if (mv[i] && mpos[i] == lat[mp[i]] - 1 && i != win) frz[mp[i]] = 1'b1;
      end
      // R4 R5 R6: presence of the oldest finished result
      check("R4/R5/R6", "wb_valid", int'(wb_valid), int'(win >= 0));
      if (win >= 0 && wb_valid) begin
         check("R2/R3", "wb_pipe", int'(wb_pipe), mp[win]);
         check("R8", "wb_tag", int'(wb_tag), mtag[win]);
         check("R9", "wb_data", int'(wb_data), mdat[win]);
      end
      ch = -1;
      case (int'(in_class))
         0: begin
            if (!frz[2]) ch = 2;
            else if (!frz[3]) ch = 3;
            else if (!frz[1]) ch = 1;
         end
         1: if (!frz[1]) ch = 1;
         2: if (!frz[0]) ch = 0;
         default: if (!frz[3]) ch = 3;
      endcase
      // R7 (and R3 fallback order): readiness
      check("R3/R7", "in_ready", int'(in_ready), int'(ch >= 0));
      acc = in_valid && (ch >= 0);
      if (win >= 0) mv[win] = 1'b0;
      for (int i = 0; i < SLOTS; i++) begin
         if (mv[i] && !frz[mp[i]]) mpos[i]++;
      end
      if (acc) begin
         for (int i = 0; i < SLOTS; i++) begin
            if (!mv[i]) begin
               mv[i]   = 1'b1;
               mp[i]   = ch;
               mpos[i] = 0;
               mseq[i] = next_seq;
               mtag[i] = int'(in_tag);
               mdat[i] = ref_result(int'(in_class), in_opa, in_opb);
               break;
            end
         end
         next_seq++;
      end
   endtask

   // Stimulus code: 0..3 class, 4 idle
   function automatic int script_code(int k);
      case (k)
         0: return 1;  1: return 4;  2: return 0;  3: return 0;
         4: return 3;  5: return 3;  6: return 2;  7: return 0;
         8: return 1;  9: return 1;  10: return 1; 11: return 0;
         12: return 0; 13: return 0; 14: return 0; 15: return 3;
         16: return 2; 17: return 2; 18: return 4; 19: return 1;
         20: return 4; 21: return 3; 22: return 0; 23: return 3;
         default: return 4;
      endcase
   endfunction

   function automatic int pick_code(int k);
      int r;
      if (k < SCRIPT_LEN) return script_code(k);
      if (k < SCRIPT_LEN + RAND_OPS) begin
         r = int'($urandom % 9);
         if (r < 3) return 0;
         if (r < 5) return 1;
         if (r < 6) return 2;
         if (r < 8) return 3;
         return 4;
      end
      return 4;
   endfunction

   initial begin
      int  k;
      bit  have;
      int  code;
      int  tagc;
      k = 0; have = 1'b0; tagc = 0;
      for (int i = 0; i < SLOTS; i++) mv[i] = 1'b0;
      void'($urandom(32'h5eed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state for every class
      @(negedge clk);
      for (int c = 0; c < 4; c++) begin
         in_class = 2'(c);
         #1;
         check("R1", "in_ready after reset", int'(in_ready), 1);
         check("R1", "wb_valid after reset", int'(wb_valid), 0);
      end
      for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
         @(negedge clk);
         if (!have) begin
            code = pick_code(k);
            k++;
            if (code < 4) begin
               in_valid = 1'b1;
               in_class = 2'(code);
               in_tag   = TW'(tagc);
               in_opa   = DW'($urandom);
               in_opb   = DW'($urandom);
               tagc++;
               have = 1'b1;
            end else begin
               in_valid = 1'b0;
            end
         end
         #1;
         model_cycle();
         if (acc) have = 1'b0;
      end
      // R4: every issued micro-op has drained
      for (int i = 0; i < SLOTS; i++) check("R4", "drained slot", int'(mv[i]), 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R4 watchdog: actual=running expected=finished at %0t", $time);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule